// File: doc/BRIEF.md
# Level-Arbitrated Interrupt Controller

This block collects interrupt causes from several interrupt systems. Each system owns a group of cause flags, one enable bit for each cause and a programmable 3-bit level. Every cycle the block finds the strongest cause that is both pending and enabled. It then drives a single request toward the processor, together with the vector number and the level of that cause. If a stronger cause turns up while a request is already being driven, the vector and level switch to the new cause, and the displaced cause stays pending.

The block also holds the processor's admission gate. This gate is a global enable bit plus a 4-bit current level. A request is taken only while the gate is open and the current level is below the requested level. When a request is taken, the current level rises to the taken level, so requests at that level or below are shut out until software lowers it again. Software reaches the flags, enables and levels through a plain write/read register port. It sets the gate through a separate write strobe.

The register address is `{system index, field}`, with a 2-bit field. Field 0 holds the cause flags, and writing 1 to a bit clears that bit. Field 1 holds the cause enables. Field 2 holds the level in bits 2:0. Field 3 is unused.

Top module: `irq_level_ctrl`

## Requirements
- R1: A one-cycle pulse on `fact_set[i]` sets cause flag i at the next clock edge. The flag then stays set until a register write to field 0 of its system carries a 1 in its bit position. A pulse arriving in the same cycle as that clearing write leaves the flag set.
- R2: The register port stores the cause enables in field 1 and the 3-bit level in bits 2:0 of field 2. Reads of fields 0, 1 and 2 return the stored value, zero-extended. Field 3 always reads as zero, and writing to it changes no stored value.
- R3: `irq_req` is raised only for a cause that is pending and enabled and whose system has a nonzero level. A system at level 0 never produces a request.
- R4: Among the qualifying causes, the one whose system holds the largest level wins. `irq_lvl` carries that system's level.
- R5: When levels are equal, the lower system index wins. Inside one system, the lower cause index wins.
- R6: `irq_vec` equals `VEC_BASE + system*N_FACT + cause` for the winning cause. It is zero when no request is driven.
- R7: The request outputs follow a change in the flags, enables or levels after one clock edge. A stronger cause that arrives while a request is driven replaces that request, and the displaced cause's flag stays set.
- R8: `irq_take` is high exactly when `irq_req` is high, the gate enable is 1 and the 4-bit current level is strictly below the zero-extended `irq_lvl`.
- R9: When a request is taken, the current level is loaded with `irq_lvl` at that edge, even if a gate write arrives in the same cycle. Taking a request clears no cause flag.
- R10: A `gate_wr` strobe loads `gate_ie` into the gate enable and `gate_il` into the current level, unless an acceptance overrides the level.
- R11: Reset clears every flag, enable and level. It also clears the gate enable and the current level, and drops the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fact_set | input | NF_TOT | One-cycle set pulses, one per cause, indexed system*N_FACT+cause |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Write address {system, field} |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_addr | input | ADDR_W | Read address {system, field} |
| reg_rd_data | output | DATA_W | Combinational read data |
| gate_wr | input | 1 | Gate write strobe |
| gate_ie | input | 1 | Gate enable value to load |
| gate_il | input | 4 | Current level value to load |
| irq_req | output | 1 | Request toward the processor |
| irq_vec | output | VEC_W | Vector number of the winning cause |
| irq_lvl | output | 3 | Level of the winning cause |
| irq_take | output | 1 | The request is accepted this cycle |
| cur_ie | output | 1 | Gate enable |
| cur_il | output | 4 | Current level |

## Verification
The checker watches four things on every cycle. It confirms that a driven request never carries level 0, and that a rising request always follows a pending, enabled cause. It confirms that the current level changes only through an acceptance or a gate write, and that an acceptance loads exactly the offered level without clearing any flag. Other behaviour needs the bench's scenarios: the choice of winner across all level pairs, the tie order between systems and within a system, the vector arithmetic, preemption while a cause stays pending, and the full grid of gate enable against current level.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

    localparam int PRIO_W = 3;
    localparam int CLVL_W = 4;
    localparam int FLD_W  = 2;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [CLVL_W-1:0] clvl_t;

    typedef enum logic [FLD_W-1:0] {
        FLD_FLAGS  = 2'd0,
        FLD_ENABLE = 2'd1,
        FLD_PRIO   = 2'd2,
        FLD_SPARE  = 2'd3
    } fld_e;

    typedef struct packed {
        logic  ie;
        clvl_t lvl;
    } gate_t;

    // Strictly greater: an equal candidate seen later in the scan loses.
    function automatic logic outranks(prio_t cand, prio_t best);
        return cand > best;
    endfunction

    function automatic logic admits(gate_t g, prio_t req_lvl);
        return g.ie && (g.lvl < {1'b0, req_lvl});
    endfunction

endpackage

// File: rtl/irq_lvl_bank.sv
module irq_lvl_bank
    import irq_lvl_pkg::*;
#(
    parameter int N_SYS  = 4,
    parameter int N_FACT = 4,
    parameter int SYS_W  = 2,
    parameter int DATA_W = 4,
    localparam int NF_TOT = N_SYS * N_FACT,
    localparam int ADDR_W = SYS_W + FLD_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NF_TOT-1:0]         set_in,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NF_TOT-1:0]         flags_o,
    output logic [NF_TOT-1:0]         en_o,
    output logic [N_SYS*PRIO_W-1:0]   prio_o
);

    logic [N_FACT-1:0] flag_q [N_SYS];
    logic [N_FACT-1:0] en_q   [N_SYS];
    prio_t             prio_q [N_SYS];

    fld_e              wr_fld;
    fld_e              rd_fld;
    logic [SYS_W-1:0]  wr_sys;
    logic [SYS_W-1:0]  rd_sys;
    logic [N_SYS-1:0]  wr_hit;

    assign wr_fld = fld_e'(wr_addr[FLD_W-1:0]);
    assign rd_fld = fld_e'(rd_addr[FLD_W-1:0]);
    assign wr_sys = wr_addr[ADDR_W-1:FLD_W];
    assign rd_sys = rd_addr[ADDR_W-1:FLD_W];

    always_comb begin
        for (int s = 0; s < N_SYS; s++) begin
            wr_hit[s] = wr_en && (wr_sys == SYS_W'(s));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < N_SYS; s++) begin
                flag_q[s] <= '0;
                en_q[s]   <= '0;
                prio_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < N_SYS; s++) begin
                // a new pulse survives a clearing write in the same cycle
                flag_q[s] <= (flag_q[s]
                              & ~({N_FACT{wr_hit[s] && (wr_fld == FLD_FLAGS)}}
                                  & wr_data[N_FACT-1:0]))
                             | set_in[s*N_FACT +: N_FACT];
                if (wr_hit[s] && (wr_fld == FLD_ENABLE)) begin
                    en_q[s] <= wr_data[N_FACT-1:0];
                end
                if (wr_hit[s] && (wr_fld == FLD_PRIO)) begin
                    prio_q[s] <= wr_data[PRIO_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < N_SYS; s++) begin
            if (rd_sys == SYS_W'(s)) begin
                case (rd_fld)
                    FLD_FLAGS:  rd_data = DATA_W'(flag_q[s]);
                    FLD_ENABLE: rd_data = DATA_W'(en_q[s]);
                    FLD_PRIO:   rd_data = DATA_W'(prio_q[s]);
                    default:    rd_data = '0;
                endcase
            end
        end
    end

    always_comb begin
        for (int s = 0; s < N_SYS; s++) begin
            flags_o[s*N_FACT +: N_FACT] = flag_q[s];
            en_o[s*N_FACT +: N_FACT]    = en_q[s];
            prio_o[s*PRIO_W +: PRIO_W]  = prio_q[s];
        end
    end

endmodule

// File: rtl/irq_lvl_arb.sv
module irq_lvl_arb
    import irq_lvl_pkg::*;
#(
    parameter int N_SYS    = 4,
    parameter int N_FACT   = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 16,
    localparam int NF_TOT  = N_SYS * N_FACT,
    localparam int IDX_W   = (NF_TOT > 1) ? $clog2(NF_TOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NF_TOT-1:0]       flags,
    input  logic [NF_TOT-1:0]       en,
    input  logic [N_SYS*PRIO_W-1:0] prio,
    output logic                    req_o,
    output logic [VEC_W-1:0]        vec_o,
    output prio_t                   lvl_o
);

    prio_t             fact_lvl [NF_TOT];
    prio_t             best_lvl;
    logic [IDX_W-1:0]  best_idx;

    // each cause inherits the level of the system it belongs to
    for (genvar gi = 0; gi < NF_TOT; gi++) begin : g_lvl
        assign fact_lvl[gi] = prio[(gi / N_FACT) * PRIO_W +: PRIO_W];
    end

    // ascending scan with strict compare: lower index wins ties,
    // level 0 never beats the initial zero
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        for (int i = 0; i < NF_TOT; i++) begin
            if (flags[i] && en[i] && outranks(fact_lvl[i], best_lvl)) begin
                best_lvl = fact_lvl[i];
                best_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o <= 1'b0;
            vec_o <= '0;
            lvl_o <= '0;
        end else begin
            req_o <= (best_lvl != '0);
            lvl_o <= best_lvl;
            vec_o <= (best_lvl != '0) ? (VEC_W'(VEC_BASE) + VEC_W'(best_idx)) : '0;
        end
    end

endmodule

// File: rtl/irq_lvl_gate.sv
module irq_lvl_gate
    import irq_lvl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  prio_t lvl,
    input  logic  wr,
    input  logic  wr_ie,
    input  clvl_t wr_lvl,
    output logic  take_o,
    output logic  ie_o,
    output clvl_t lvl_o
);

    gate_t st_q;

    assign take_o = req && admits(st_q, lvl);
    assign ie_o   = st_q.ie;
    assign lvl_o  = st_q.lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (wr) begin
                st_q.ie <= wr_ie;
            end
            // acceptance outranks a software write of the level
            if (take_o) begin
                st_q.lvl <= {1'b0, lvl};
            end else if (wr) begin
                st_q.lvl <= wr_lvl;
            end
        end
    end

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_lvl_pkg::*;
#(
    parameter int N_SYS    = 4,
    parameter int N_FACT   = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 16,
    localparam int SYS_W   = (N_SYS > 1) ? $clog2(N_SYS) : 1,
    localparam int NF_TOT  = N_SYS * N_FACT,
    localparam int ADDR_W  = SYS_W + FLD_W,
    localparam int DATA_W  = (N_FACT > PRIO_W) ? N_FACT : PRIO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NF_TOT-1:0] fact_set,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              gate_wr,
    input  logic              gate_ie,
    input  logic [3:0]        gate_il,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [2:0]        irq_lvl,
    output logic              irq_take,
    output logic              cur_ie,
    output logic [3:0]        cur_il
);

    logic [NF_TOT-1:0]       flag_flat;
    logic [NF_TOT-1:0]       en_flat;
    logic [N_SYS*PRIO_W-1:0] prio_flat;

    irq_lvl_bank #(
        .N_SYS  (N_SYS),
        .N_FACT (N_FACT),
        .SYS_W  (SYS_W),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_in  (fact_set),
        .wr_en   (reg_wr),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .flags_o (flag_flat),
        .en_o    (en_flat),
        .prio_o  (prio_flat)
    );

    irq_lvl_arb #(
        .N_SYS    (N_SYS),
        .N_FACT   (N_FACT),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE)
    ) u_arb (
        .clk   (clk),
        .rst   (rst),
        .flags (flag_flat),
        .en    (en_flat),
        .prio  (prio_flat),
        .req_o (irq_req),
        .vec_o (irq_vec),
        .lvl_o (irq_lvl)
    );

    irq_lvl_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .req    (irq_req),
        .lvl    (irq_lvl),
        .wr     (gate_wr),
        .wr_ie  (gate_ie),
        .wr_lvl (gate_il),
        .take_o (irq_take),
        .ie_o   (cur_ie),
        .lvl_o  (cur_il)
    );

endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
    parameter int NF_TOT = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_req,
    input logic [2:0]        irq_lvl,
    input logic              irq_take,
    input logic              cur_ie,
    input logic [3:0]        cur_il,
    input logic              gate_wr,
    input logic              reg_wr,
    input logic [NF_TOT-1:0] flags,
    input logic [NF_TOT-1:0] en
);

    a_r11_idle_after_reset: assert property (@(posedge clk)
        rst |=> (!irq_req && !cur_ie && (cur_il == 4'd0)));

    a_r3_req_has_level: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_lvl != 3'd0));

    a_r3_req_from_pending: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(|(flags & en)));

    a_r9_accept_loads_level: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> (cur_il == {1'b0, $past(irq_lvl)}));

    a_r10_gate_holds: assert property (@(posedge clk) disable iff (rst)
        (!irq_take && !gate_wr) |=> ($stable(cur_il) && $stable(cur_ie)));

    a_r9_no_flag_loss: assert property (@(posedge clk) disable iff (rst)
        (irq_take && !reg_wr) |=> ($countones(flags) >= $past($countones(flags))));

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NF_TOT(NF_TOT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_req  (irq_req),
    .irq_lvl  (irq_lvl),
    .irq_take (irq_take),
    .cur_ie   (cur_ie),
    .cur_il   (cur_il),
    .gate_wr  (gate_wr),
    .reg_wr   (reg_wr),
    .flags    (flag_flat),
    .en       (en_flat)
);

// File: tb/irq_level_ctrl_tb.sv
`timescale 1ns/1ps
module irq_level_ctrl_tb;

    localparam int NF = 16;
    localparam int VB = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NF-1:0] fact_set = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_wr_addr = '0;
    logic [3:0]  reg_wr_data = '0;
    logic [3:0]  reg_rd_addr = '0;
    logic [3:0]  reg_rd_data;
    logic        gate_wr = 1'b0;
    logic        gate_ie = 1'b0;
    logic [3:0]  gate_il = '0;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic [2:0]  irq_lvl;
    logic        irq_take;
    logic        cur_ie;
    logic [3:0]  cur_il;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_level_ctrl u_dut (
        .clk(clk), .rst(rst), .fact_set(fact_set),
        .reg_wr(reg_wr), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .gate_wr(gate_wr), .gate_ie(gate_ie), .gate_il(gate_il),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .irq_take(irq_take), .cur_ie(cur_ie), .cur_il(cur_il)
    );

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wreg(int s, int f, int d);
        reg_wr      = 1'b1;
        reg_wr_addr = 4'(s * 4 + f);
        reg_wr_data = 4'(d);
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rreg(int s, int f, output int v);
        reg_rd_addr = 4'(s * 4 + f);
        #0.5;
        v = int'(reg_rd_data);
    endtask

    task automatic pulse(int idx);
        fact_set[idx] = 1'b1;
        step();
        fact_set = '0;
    endtask

    task automatic set_gate(int ie, int il);
        gate_wr = 1'b1;
        gate_ie = 1'(ie);
        gate_il = 4'(il);
        step();
        gate_wr = 1'b0;
    endtask

    task automatic clear_all();
        for (int s = 0; s < 4; s++) begin
            wreg(s, 1, 0);
            wreg(s, 2, 0);
            wreg(s, 0, 15);
        end
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R11: reset state
        chk("R11 req", int'(irq_req), 0);
        chk("R11 ie", int'(cur_ie), 0);
        chk("R11 il", int'(cur_il), 0);
        for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < 4; f++) begin
                rreg(s, f, v);
                chk("R11 regs", v, 0);
            end
        end

        // R2: register storage and the spare field
        wreg(1, 1, 4'b1010);
        rreg(1, 1, v); chk("R2 enable", v, 10);
        wreg(1, 2, 5);
        rreg(1, 2, v); chk("R2 prio", v, 5);
        wreg(1, 2, 15);
        rreg(1, 2, v); chk("R2 prio width", v, 7);
        wreg(1, 3, 15);
        rreg(1, 3, v); chk("R2 spare", v, 0);
        rreg(1, 1, v); chk("R2 spare no effect en", v, 10);
        rreg(1, 2, v); chk("R2 spare no effect prio", v, 7);
        clear_all();

        // R1: set, hold, write-one-to-clear, set beats clear
        pulse(5);
        rreg(1, 0, v); chk("R1 set", v, 2);
        repeat (3) step();
        rreg(1, 0, v); chk("R1 hold", v, 2);
        wreg(1, 0, 1);
        rreg(1, 0, v); chk("R1 clear other bit", v, 2);
        wreg(1, 0, 2);
        rreg(1, 0, v); chk("R1 cleared", v, 0);
        fact_set[5] = 1'b1;
        wreg(1, 0, 2);
        fact_set = '0;
        rreg(1, 0, v); chk("R1 set wins", v, 2);

        // R3: level 0 blocks, then level 4 requests; R6 vector
        wreg(1, 1, 2);
        step();
        chk("R3 level zero", int'(irq_req), 0);
        wreg(1, 2, 4);
        step();
        chk("R3 req", int'(irq_req), 1);
        chk("R6 vec", int'(irq_vec), VB + 5);
        chk("R4 lvl", int'(irq_lvl), 4);
        wreg(1, 1, 0);
        step();
        chk("R3 disabled", int'(irq_req), 0);
        chk("R6 vec idle", int'(irq_vec), 0);

        // R7: one edge of latency from flag to request
        wreg(1, 0, 15);
        wreg(1, 1, 2);
        step();
        chk("R7 idle before", int'(irq_req), 0);
        pulse(5);
        chk("R7 not yet", int'(irq_req), 0);
        step();
        chk("R7 after one edge", int'(irq_req), 1);
        clear_all();

        // R4/R5 sweep: cause 5 (sys1) against cause 8 (sys2)
        wreg(1, 1, 2);
        wreg(2, 1, 1);
        pulse(5);
        pulse(8);
        for (int pa = 0; pa < 8; pa++) begin
            for (int pb = 0; pb < 8; pb++) begin
                int er, ev, el;
                wreg(1, 2, pa);
                wreg(2, 2, pb);
                step();
                er = (pa != 0 || pb != 0) ? 1 : 0;
                el = (pa >= pb) ? pa : pb;
                ev = (er == 0) ? 0 : ((pa >= pb) ? VB + 5 : VB + 8);
                chk("R3 sweep req", int'(irq_req), er);
                chk("R4 sweep lvl", int'(irq_lvl), el);
                chk("R5 sweep vec", int'(irq_vec), ev);
            end
        end
        clear_all();

        // R5: within one system, then across systems at equal level
        wreg(3, 1, 4'b0101);
        wreg(3, 2, 6);
        pulse(14);
        pulse(12);
        step();
        chk("R5 within system", int'(irq_vec), VB + 12);
        wreg(1, 1, 2);
        wreg(1, 2, 6);
        pulse(5);
        step();
        chk("R5 across systems", int'(irq_vec), VB + 5);
        clear_all();

        // R7: preemption with the loser left pending
        wreg(2, 1, 1);
        wreg(2, 2, 3);
        wreg(1, 1, 2);
        wreg(1, 2, 5);
        pulse(8);
        step();
        chk("R7 first vec", int'(irq_vec), VB + 8);
        chk("R7 first lvl", int'(irq_lvl), 3);
        pulse(5);
        step();
        chk("R7 preempt vec", int'(irq_vec), VB + 5);
        chk("R7 preempt lvl", int'(irq_lvl), 5);
        rreg(2, 0, v); chk("R7 loser pending", v, 1);
        wreg(1, 0, 2);
        step();
        chk("R7 revert vec", int'(irq_vec), VB + 8);
        clear_all();

        // R8/R9/R10: gate grid against every request level
        wreg(2, 1, 1);
        pulse(8);
        for (int lv = 1; lv < 8; lv++) begin
            wreg(2, 2, lv);
            step();
            chk("R4 gate lvl", int'(irq_lvl), lv);
            for (int ie = 0; ie < 2; ie++) begin
                for (int il = 0; il < 16; il++) begin
                    int et;
                    set_gate(ie, il);
                    chk("R10 ie", int'(cur_ie), ie);
                    chk("R10 il", int'(cur_il), il);
                    et = (ie == 1 && il < lv) ? 1 : 0;
                    chk("R8 take", int'(irq_take), et);
                    step();
                    chk("R9 level after", int'(cur_il), (et == 1) ? lv : il);
                    chk("R9 flag kept", int'(irq_req), 1);
                    set_gate(0, 0);
                end
            end
        end
        rreg(2, 0, v); chk("R9 flag still set", v, 1);

        // R9: acceptance beats a same-cycle gate write of the level
        wreg(2, 2, 5);
        step();
        set_gate(1, 2);
        chk("R8 take before race", int'(irq_take), 1);
        set_gate(1, 9);
        chk("R9 precedence il", int'(cur_il), 5);
        chk("R9 precedence ie", int'(cur_ie), 1);
        chk("R9 no retake", int'(irq_take), 0);
        set_gate(0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule